// File: doc/BRIEF.md
# I/Q Output Port Formatter with RSSI Append

This block takes I/Q samples from up to six gain-controlled receive channels and serializes them onto a single 16-bit output stream. Each channel offers one sample at a time on its own valid/ready input. A one-deep buffer holds the sample, and a round-robin arbiter picks the next buffered sample from the enabled channels. A per-channel enable mask selects which sources reach the port. The samples of a disabled channel are taken and discarded.

A format control selects the word layout. In narrow mode the upper bytes of I and Q share one word. In wide mode the full I word goes out first and the full Q word follows. Each channel also keeps its latest signal-strength (RSSI) word and a flag showing that the word is new. With the append control set, an RSSI word follows every sample. With it clear, an RSSI word follows only the first sample loaded after an update. Every output word carries the channel number and three type flags: bit 0 marks I, bit 1 marks Q and bit 2 marks RSSI.

Back-pressure follows valid/ready rules. A word moves when `out_valid` and `out_ready` are both high at a clock edge. While `out_ready` is low, the presented word is held unchanged. On each input, a sample moves when `in_valid` and `in_ready` are high together. `in_ready` of an enabled channel is low while its buffer is full. The format and append controls take effect when a sample is loaded into the serializer.

Top module: `iq_port_formatter`

## Requirements
- R1: After reset `out_valid` is low and every `in_ready` bit is high.
- R2: A sample offered to a channel whose `ch_en` bit is low is accepted (`in_ready` high) and never appears on the output.
- R3: In narrow mode (`fmt_narrow`=1) a sample produces one word {I[15:8], Q[15:8]} with `out_flags`=3'b011.
- R4: In wide mode (`fmt_narrow`=0) a sample produces the I word with `out_flags`=3'b001, then the Q word with `out_flags`=3'b010.
- R5: With `rssi_always`=1, every sample is followed by one word with `out_flags`=3'b100 carrying the channel's latest RSSI value, whether or not it was updated.
- R6: With `rssi_always`=0, an RSSI word follows only the first sample of that channel loaded after a `rssi_upd` pulse; later samples carry none until the next update.
- R7: When several enabled channels hold samples, the next one served is the first enabled, buffered channel after the one served last, counting upward and wrapping past 5 to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_ch` and `out_flags` stay unchanged at the next edge.
- R9: An enabled channel holds one waiting sample. Its `in_ready` is low while that sample waits, and no accepted sample is lost or reordered within a channel.
- R10: `out_ch` gives the number (0 to 5) of the channel that every output word belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 6 | Per-channel enable mask |
| fmt_narrow | input | 1 | 1: one byte-packed I/Q word; 0: I word then Q word |
| rssi_always | input | 1 | 1: RSSI after every sample; 0: only after an update |
| in_valid | input | 6 | Per-channel sample valid |
| in_ready | output | 6 | Per-channel sample ready |
| in_i | input | 96 | I samples, channel n at bits [16n+15:16n] |
| in_q | input | 96 | Q samples, same packing |
| rssi_upd | input | 6 | One-cycle RSSI update strobe per channel |
| rssi_val | input | 96 | RSSI values, same packing |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 16 | Output word |
| out_ch | output | 3 | Channel number of the word |
| out_flags | output | 3 | Word type: bit0 I, bit1 Q, bit2 RSSI |

## Verification
A sample accepted at edge e fills its buffer at e. With the serializer idle, the first word goes out at e+1 and the following words go out on successive handshakes. An RSSI strobe at edge e counts for any sample loaded at e+1 or later. The bench never counts cycles to these points. A driver waits for each input handshake and pushes the expected words into a scoreboard queue. A monitor samples on the falling clock edge and pops one entry on every handshake, so the result is checked whenever it is actually due. Stall stability is checked on every falling edge after a stalled word. The bench changes the controls only after the queue has drained.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PAR  = 3'd1,
    ST_I    = 3'd2,
    ST_Q    = 3'd3,
    ST_R    = 3'd4
  } ser_st_e;

  localparam logic [2:0] FLG_I   = 3'b001;
  localparam logic [2:0] FLG_Q   = 3'b010;
  localparam logic [2:0] FLG_PAR = 3'b011;
  localparam logic [2:0] FLG_R   = 3'b100;
endpackage

// File: rtl/iqf_chan_buf.sv
module iqf_chan_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic          pop,
  output logic          full,
  output logic [DW-1:0] buf_i,
  output logic [DW-1:0] buf_q,
  input  logic          rssi_upd,
  input  logic [DW-1:0] rssi_val,
  input  logic          rssi_clr,
  output logic          rssi_pend,
  output logic [DW-1:0] rssi_word
);
  logic wr;

  assign in_ready = !en || !full;
  assign wr       = in_valid && en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      buf_i <= '0;
      buf_q <= '0;
    end else if (wr) begin
      full  <= 1'b1;
      buf_i <= in_i;
      buf_q <= in_q;
    end else if (pop) begin
      full  <= 1'b0;
    end
  end

  // a fresh update wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rssi_pend <= 1'b0;
      rssi_word <= '0;
    end else if (rssi_upd) begin
      rssi_pend <= 1'b1;
      rssi_word <= rssi_val;
    end else if (rssi_clr) begin
      rssi_pend <= 1'b0;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && $stable(buf_i) && $stable(buf_q));

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_upd |=> rssi_pend && (rssi_word == $past(rssi_val)));
endmodule

// File: rtl/iqf_rr_arb.sv
module iqf_rr_arb #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last;

  always_comb begin
    gnt_idx = '0;
    gnt_any = 1'b0;
    // scan from farthest to nearest so the nearest requester wins
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        gnt_idx = IW'(idx);
        gnt_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= IW'(N - 1);
    else if (adv) last <= gnt_idx;
  end

  p_gnt_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> gnt_any && req[gnt_idx]);
endmodule

// File: rtl/iq_port_formatter.sv
module iq_port_formatter
  import iqf_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_en,
  input  logic              fmt_narrow,
  input  logic              rssi_always,
  input  logic [NCH-1:0]    in_valid,
  output logic [NCH-1:0]    in_ready,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  input  logic [NCH-1:0]    rssi_upd,
  input  logic [NCH*DW-1:0] rssi_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [CHW-1:0]    out_ch,
  output logic [2:0]        out_flags
);
  localparam int HW = DW / 2;

  logic [NCH-1:0] full, pend, pop, req;
  logic [DW-1:0]  b_i [NCH];
  logic [DW-1:0]  b_q [NCH];
  logic [DW-1:0]  b_r [NCH];

  logic [CHW-1:0] gnt_idx;
  logic           gnt_any;

  ser_st_e        st;
  logic [DW-1:0]  h_i, h_q, h_r;
  logic [CHW-1:0] h_ch;
  logic           h_send_r;
  logic           hs, last_word, load;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    iqf_chan_buf #(.DW(DW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[g]),
      .in_valid (in_valid[g]),
      .in_ready (in_ready[g]),
      .in_i     (in_i[g*DW +: DW]),
      .in_q     (in_q[g*DW +: DW]),
      .pop      (pop[g]),
      .full     (full[g]),
      .buf_i    (b_i[g]),
      .buf_q    (b_q[g]),
      .rssi_upd (rssi_upd[g]),
      .rssi_val (rssi_val[g*DW +: DW]),
      .rssi_clr (pop[g]),
      .rssi_pend(pend[g]),
      .rssi_word(b_r[g])
    );
    assign pop[g] = load && (gnt_idx == CHW'(g));
  end

  assign req = full & ch_en;

  iqf_rr_arb #(.N(NCH), .IW(CHW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .adv    (load),
    .gnt_idx(gnt_idx),
    .gnt_any(gnt_any)
  );

  assign hs        = out_valid && out_ready;
  assign last_word = (st == ST_R) ||
                     ((st == ST_PAR || st == ST_Q) && !h_send_r);
  assign load      = gnt_any && ((st == ST_IDLE) || (hs && last_word));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      h_i      <= '0;
      h_q      <= '0;
      h_r      <= '0;
      h_ch     <= '0;
      h_send_r <= 1'b0;
    end else if (load) begin
      st       <= fmt_narrow ? ST_PAR : ST_I;
      h_i      <= b_i[gnt_idx];
      h_q      <= b_q[gnt_idx];
      h_r      <= b_r[gnt_idx];
      h_ch     <= gnt_idx;
      h_send_r <= rssi_always || pend[gnt_idx];
    end else if (hs) begin
      unique case (st)
        ST_I:          st <= ST_Q;
        ST_PAR, ST_Q:  st <= h_send_r ? ST_R : ST_IDLE;
        default:       st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (st != ST_IDLE);
    out_ch    = h_ch;
    unique case (st)
      ST_PAR:  begin out_data = {h_i[DW-1:HW], h_q[DW-1:HW]}; out_flags = FLG_PAR; end
      ST_I:    begin out_data = h_i; out_flags = FLG_I; end
      ST_Q:    begin out_data = h_q; out_flags = FLG_Q; end
      ST_R:    begin out_data = h_r; out_flags = FLG_R; end
      default: begin out_data = '0;  out_flags = 3'b000; end
    endcase
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_ch) && $stable(out_flags));

  p_flags_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags != 3'b000) &&
                  (!out_flags[2] || out_flags[1:0] == 2'b00));

  p_ch_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_ch) < NCH));
endmodule

// File: tb/test_iq_port_formatter.sv
module test_iq_port_formatter;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    ch_en = '1;
  logic              fmt_narrow = 1'b0;
  logic              rssi_always = 1'b0;
  logic [NCH-1:0]    in_valid = '0;
  logic [NCH-1:0]    in_ready;
  logic [NCH*DW-1:0] in_i = '0;
  logic [NCH*DW-1:0] in_q = '0;
  logic [NCH-1:0]    rssi_upd = '0;
  logic [NCH*DW-1:0] rssi_val = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DW-1:0]     out_data;
  logic [2:0]        out_ch;
  logic [2:0]        out_flags;

  always #2.5 clk = ~clk;

  iq_port_formatter i_iq_port_formatter (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .fmt_narrow(fmt_narrow),
    .rssi_always(rssi_always), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .rssi_upd(rssi_upd), .rssi_val(rssi_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ch(out_ch), .out_flags(out_flags)
  );

  int checks = 0;
  int fails  = 0;
  int unexpected = 0;
  bit done = 0;

  logic [21:0] exp_q[$];
  string       tag_q[$];
  logic [DW-1:0] rssi_m [NCH];
  bit            pend_m [NCH];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int ch, input logic [2:0] fl, input logic [DW-1:0] d, input string req);
    exp_q.push_back({3'(ch), fl, d});
    tag_q.push_back(req);
  endtask

  task automatic expect_sample(input int ch, input logic [DW-1:0] i, input logic [DW-1:0] q, input string req);
    if (fmt_narrow) expect_word(ch, 3'b011, {i[15:8], q[15:8]}, {req, "/R3"});
    else begin
      expect_word(ch, 3'b001, i, {req, "/R4"});
      expect_word(ch, 3'b010, q, {req, "/R4"});
    end
    if (rssi_always) expect_word(ch, 3'b100, rssi_m[ch], {req, "/R5"});
    else if (pend_m[ch]) expect_word(ch, 3'b100, rssi_m[ch], {req, "/R6"});
    pend_m[ch] = 0;
  endtask

  task automatic drive(input int ch, input logic [DW-1:0] i, input logic [DW-1:0] q);
    @(posedge clk); #1;
    in_valid[ch] = 1'b1;
    in_i[ch*DW +: DW] = i;
    in_q[ch*DW +: DW] = q;
    do @(negedge clk); while (!in_ready[ch]);
    @(posedge clk); #1;
    in_valid[ch] = 1'b0;
  endtask

  task automatic push(input int ch, input logic [DW-1:0] i, input logic [DW-1:0] q, input string req);
    if (ch_en[ch]) expect_sample(ch, i, q, req);
    drive(ch, i, q);
  endtask

  task automatic upd(input int ch, input logic [DW-1:0] v);
    @(posedge clk); #1;
    rssi_upd[ch] = 1'b1;
    rssi_val[ch*DW +: DW] = v;
    @(posedge clk); #1;
    rssi_upd[ch] = 1'b0;
    rssi_m[ch] = v;
    pend_m[ch] = 1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // monitor: sample at falling edge, pop on each handshake
  logic [21:0] stall_w;
  bit          stalled = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled)
        chk(out_valid && ({out_ch, out_flags, out_data} == stall_w), "R8",
            {9'd0, out_valid, out_ch, out_flags, out_data}, {10'd1, stall_w});
      stalled = out_valid && !out_ready;
      stall_w = {out_ch, out_flags, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          unexpected++;
          chk(0, "R2/R6 unexpected word", {10'd0, out_ch, out_flags, out_data}, 0);
        end else begin
          logic [21:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_ch, out_flags, out_data} == e, {t, "/R10"},
              {10'd0, out_ch, out_flags, out_data}, {10'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin rssi_m[c] = '0; pend_m[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 0);
    chk(in_ready == '1, "R1 in_ready", {26'd0, in_ready}, 32'h3f);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R4/R10: wide mode, no RSSI pending
    push(1, 16'h1234, 16'h5678, "R4");
    push(3, 16'hA1B2, 16'hC3D4, "R10");
    drain();

    // R6: RSSI only once after an update
    upd(1, 16'h0F0E);
    push(1, 16'h1111, 16'h2222, "R6");
    push(1, 16'h3333, 16'h4444, "R6");
    drain();

    // R3: narrow mode, with and without an RSSI word
    fmt_narrow = 1'b1;
    push(3, 16'hABCD, 16'h9876, "R3");
    upd(3, 16'h00C8);
    push(3, 16'h5A5A, 16'hA5A5, "R3");
    push(3, 16'hFF00, 16'h00FF, "R3");
    drain();

    // R5: RSSI after every sample, wide mode
    fmt_narrow = 1'b0;
    rssi_always = 1'b1;
    push(4, 16'h0101, 16'h0202, "R5");
    upd(4, 16'h7E7E);
    push(4, 16'h0303, 16'h0404, "R5");
    push(4, 16'h0505, 16'h0606, "R5");
    push(2, 16'h0707, 16'h0808, "R5");
    drain();
    rssi_always = 1'b0;

    // R2: disabled channel drops its samples
    ch_en = 6'b111011;
    push(2, 16'hDEAD, 16'hBEEF, "R2");
    #1;
    chk(in_ready[2] == 1'b1, "R2 in_ready", {31'd0, in_ready[2]}, 1);
    repeat (10) @(posedge clk);
    chk(unexpected == 0, "R2 nothing sent", unexpected, 0);
    ch_en = '1;
    drain();

    // R7/R9: round robin under stall
    fmt_narrow = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    drive(5, 16'h5500, 16'h5511);
    drive(2, 16'h2200, 16'h2211);
    drive(0, 16'h0000, 16'h0011);
    @(negedge clk);
    chk(in_ready[2] == 1'b0, "R9 ch2 full", {31'd0, in_ready[2]}, 0);
    chk(in_ready[0] == 1'b0, "R9 ch0 full", {31'd0, in_ready[0]}, 0);
    chk(in_ready[5] == 1'b1, "R9 ch5 taken", {31'd0, in_ready[5]}, 1);
    expect_sample(5, 16'h5500, 16'h5511, "R7");
    expect_sample(0, 16'h0000, 16'h0011, "R7");
    expect_sample(2, 16'h2200, 16'h2211, "R7");
    repeat (5) @(posedge clk);
    #1;
    out_ready = 1'b1;
    drain();

    // R8/R9: toggling back-pressure on one channel stream
    fmt_narrow = 1'b0;
    rssi_always = 1'b1;
    fork
      begin
        for (int n = 0; n < 20; n++)
          push(0, 16'(n * 16'h0111), 16'(16'hF000 - n), "R9");
        drain();
      end
      begin
        logic [7:0] lf;
        lf = 8'hA7;
        while (exp_q.size() != 0 || in_valid != 0 || lf != 8'hA7) begin
          @(posedge clk); #1;
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          out_ready = lf[0] | lf[2];
          if (exp_q.size() == 0 && in_valid == 0) lf = 8'hA7;
        end
        out_ready = 1'b1;
      end
    join
    rssi_always = 1'b0;
    drain();

    chk(exp_q.size() == 0, "R9 all words seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule